// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block models the command decoder that sits inside a 16-bit parallel NOR flash and answers a host bus as a slave. Bus writes never land in the storage directly. Instead the decoder looks for a keyed two-write unlock prefix followed by a command word. The command either switches the read path to the identification words, arms a single program cycle, or (without any prefix) switches it to the query table. A reset command brings the part back to ordinary array reads.

The storage is a small word array that powers up erased (all ones). A program cycle can only clear bits, because the new word is the AND of the old word and the written data. Reads are registered. The read path picks between the array, the identification pair and the query table, according to the current read mode. Erase, sector protection, status polling and flash timing are not modelled.

Top module: `norCmdIf`

## Requirements
- R1: After reset the read mode is array read, `busRdData` is 0x0000 and every array word reads 0xFFFF.
- R2: A read strobe in cycle n loads `busRdData` at the following clock edge, so it is valid from cycle n+1. `busRdData` then holds its value until the next read strobe.
- R3: The ID command is three writes: 0xAA to word address 0x555, then 0x55 to 0x2AA, then 0x90 to 0x555. Commands are compared on data bits 7:0 against the full word address. In ID mode, address 0 reads 0x00C2, address 1 reads 0x2249 and every other address reads 0x0000.
- R4: A write of 0x98 to word address 0x055 enters query mode from any sequence state except an armed program cycle, and needs no prefix. In query mode, addresses 0x10, 0x11 and 0x12 read 0x0051, 0x0052 and 0x0059. Address 0x27 reads the log2 of the device size in bytes, which is 0x0015 by default. Every other address reads 0x0000.
- R5: A write with 0xF0 in bits 7:0 to any address, when no program cycle is armed, returns to array read and drops any partly received unlock sequence.
- R6: The unlock prefix followed by 0xA0 written to 0x555 arms a program cycle. The next write, whatever its address and data, sets the addressed word to (old AND data). It disarms the cycle and leaves the block in array read mode.
- R7: A write that is not part of a complete command sequence never changes the array. A write that breaks the unlock sequence returns the decoder to idle, so a later command needs a fresh prefix.
- R8: The array holds ARRAY_WORDS words, indexed by the low log2(ARRAY_WORDS) bits of the word address. Higher address bits alias for both reads and programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, one cycle per read |
| busAddr | input | ADDR_W | Word address |
| busWrData | input | 16 | Write data; commands in bits 7:0 |
| busRdData | output | 16 | Registered read data |

## Verification
The assertions assume that the host never raises the read and write strobes in the same cycle, and that each strobe is a single-cycle pulse with the address and data valid in that cycle. The bench's bus tasks drive exactly one strobe for one cycle and then return it low, and random sequences are built only from these tasks. The random mix uses real unlock prefixes, prefixes broken at either step, stray reset and query commands, and plain writes. This keeps the armed and broken-sequence paths exercised while staying within that bus contract.

// File: rtl/norCmdPkg.sv
package norCmdPkg;

  typedef enum logic [1:0] {
    RD_ARRAY = 2'd0,
    RD_ID    = 2'd1,
    RD_CFI   = 2'd2
  } rdMode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_KEY1  = 2'd1,
    SEQ_KEY2  = 2'd2,
    SEQ_ARMED = 2'd3
  } seq_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    progStb;
    rdMode_e rdMode;
  } ctrlStb_t;

  localparam logic [7:0]  CMD_KEY1  = 8'hAA;
  localparam logic [7:0]  CMD_KEY2  = 8'h55;
  localparam logic [7:0]  CMD_ID    = 8'h90;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_RESET = 8'hF0;
  localparam logic [7:0]  CMD_QUERY = 8'h98;

  localparam logic [11:0] ADR_KEYA  = 12'h555;
  localparam logic [11:0] ADR_KEYB  = 12'h2AA;
  localparam logic [11:0] ADR_QUERY = 12'h055;

endpackage

// File: rtl/norCmdCtrl.sv
module norCmdCtrl
  import norCmdPkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        cmdByte,
  output ctrlStb_t          stb,
  output logic              armed
);

  seq_e    seqQ, seqD;
  rdMode_e modeQ, modeD;
  logic    progD;

  logic atKeyA, atKeyB, atQuery;
  assign atKeyA  = (busAddr == ADDR_W'(ADR_KEYA));
  assign atKeyB  = (busAddr == ADDR_W'(ADR_KEYB));
  assign atQuery = (busAddr == ADDR_W'(ADR_QUERY));

  always_comb begin
    seqD  = seqQ;
    modeD = modeQ;
    progD = 1'b0;
    if (busWr) begin
      if (seqQ == SEQ_ARMED) begin
        progD = 1'b1;
        seqD  = SEQ_IDLE;
        modeD = RD_ARRAY;
      end else if (cmdByte == CMD_RESET) begin
        seqD  = SEQ_IDLE;
        modeD = RD_ARRAY;
      end else if (cmdByte == CMD_QUERY && atQuery) begin
        seqD  = SEQ_IDLE;
        modeD = RD_CFI;
      end else begin
        unique case (seqQ)
          SEQ_IDLE: seqD = (cmdByte == CMD_KEY1 && atKeyA) ? SEQ_KEY1 : SEQ_IDLE;
          SEQ_KEY1: seqD = (cmdByte == CMD_KEY2 && atKeyB) ? SEQ_KEY2 : SEQ_IDLE;
          SEQ_KEY2: begin
            seqD = SEQ_IDLE;
            if (atKeyA && cmdByte == CMD_ID)        modeD = RD_ID;
            else if (atKeyA && cmdByte == CMD_PROG) seqD  = SEQ_ARMED;
          end
          default: seqD = SEQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqQ  <= SEQ_IDLE;
      modeQ <= RD_ARRAY;
    end else begin
      seqQ  <= seqD;
      modeQ <= modeD;
    end
  end

  assign stb.progStb = progD;
  assign stb.rdMode  = modeQ;
  assign armed       = (seqQ == SEQ_ARMED);

endmodule

// File: rtl/norCmdQuery.sv
module norCmdQuery #(
  parameter int          ADDR_W    = 20,
  parameter int          SIZE_LOG2 = 21,
  parameter logic [15:0] MFR_ID    = 16'h00C2,
  parameter logic [15:0] DEV_ID    = 16'h2249
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [15:0]       idWord,
  output logic [15:0]       cfiWord
);

  localparam logic [ADDR_W-1:0] Q_ADR_Q    = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] Q_ADR_R    = ADDR_W'(8'h11);
  localparam logic [ADDR_W-1:0] Q_ADR_Y    = ADDR_W'(8'h12);
  localparam logic [ADDR_W-1:0] Q_ADR_SIZE = ADDR_W'(8'h27);

  always_comb begin
    if (addr == '0)                 idWord = MFR_ID;
    else if (addr == ADDR_W'(1))    idWord = DEV_ID;
    else                            idWord = 16'h0000;
  end

  always_comb begin
    if (addr == Q_ADR_Q)            cfiWord = 16'h0051;
    else if (addr == Q_ADR_R)       cfiWord = 16'h0052;
    else if (addr == Q_ADR_Y)       cfiWord = 16'h0059;
    else if (addr == Q_ADR_SIZE)    cfiWord = 16'(SIZE_LOG2);
    else                            cfiWord = 16'h0000;
  end

endmodule

// File: rtl/norCmdData.sv
module norCmdData
  import norCmdPkg::*;
#(
  parameter int          ADDR_W      = 20,
  parameter int          ARRAY_WORDS = 64,
  parameter int          SIZE_LOG2   = 21,
  parameter logic [15:0] MFR_ID      = 16'h00C2,
  parameter logic [15:0] DEV_ID      = 16'h2249
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWrData,
  output logic [15:0]       busRdData
);

  localparam int ARR_AW = (ARRAY_WORDS > 1) ? $clog2(ARRAY_WORDS) : 1;

  logic [ARRAY_WORDS-1:0][15:0] mem;
  logic [ARRAY_WORDS-1:0]       wordHit;
  logic [ARR_AW-1:0]            wordIdx;
  logic [15:0]                  idWord, cfiWord, arrWord;

  assign wordIdx = busAddr[ARR_AW-1:0];

  for (genvar g = 0; g < ARRAY_WORDS; g++) begin : gHit
    assign wordHit[g] = (wordIdx == ARR_AW'(g));
  end

  assign arrWord = mem[wordIdx];

  // Program can only clear bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mem <= '1;
    end else if (stb.progStb) begin
      for (int i = 0; i < ARRAY_WORDS; i++) begin
        if (wordHit[i]) mem[i] <= mem[i] & busWrData;
      end
    end
  end

  norCmdQuery #(
    .ADDR_W   (ADDR_W),
    .SIZE_LOG2(SIZE_LOG2),
    .MFR_ID   (MFR_ID),
    .DEV_ID   (DEV_ID)
  ) u_query (
    .addr   (busAddr),
    .idWord (idWord),
    .cfiWord(cfiWord)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdData <= 16'h0000;
    end else if (busRd) begin
      unique case (stb.rdMode)
        RD_ID:   busRdData <= idWord;
        RD_CFI:  busRdData <= cfiWord;
        default: busRdData <= arrWord;
      endcase
    end
  end

endmodule

// File: rtl/norCmdIf.sv
module norCmdIf
  import norCmdPkg::*;
#(
  parameter int          ADDR_W      = 20,
  parameter int          ARRAY_WORDS = 64,
  parameter int          SIZE_LOG2   = 21,
  parameter logic [15:0] MFR_ID      = 16'h00C2,
  parameter logic [15:0] DEV_ID      = 16'h2249
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWrData,
  output logic [15:0]       busRdData
);

  ctrlStb_t ctrlStb;
  logic     seqArmed;

  norCmdCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busWr  (busWr),
    .busAddr(busAddr),
    .cmdByte(busWrData[7:0]),
    .stb    (ctrlStb),
    .armed  (seqArmed)
  );

  norCmdData #(
    .ADDR_W     (ADDR_W),
    .ARRAY_WORDS(ARRAY_WORDS),
    .SIZE_LOG2  (SIZE_LOG2),
    .MFR_ID     (MFR_ID),
    .DEV_ID     (DEV_ID)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (ctrlStb),
    .busRd    (busRd),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .busRdData(busRdData)
  );

endmodule

// File: rtl/norCmdChk.sv
module norCmdChk
  import norCmdPkg::*;
#(
  parameter int          ADDR_W = 20,
  parameter logic [15:0] MFR_ID = 16'h00C2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic              busRd,
  input logic [ADDR_W-1:0] busAddr,
  input logic [15:0]       busWrData,
  input logic [15:0]       busRdData,
  input rdMode_e           rdMode,
  input logic              armed,
  input logic              progStb
);

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr)); // R2

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdData)); // R2

  AST_ID_MFR: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && rdMode == RD_ID && busAddr == '0) |=> busRdData == MFR_ID); // R3

  AST_CFI_Q: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && rdMode == RD_CFI && busAddr == ADDR_W'(8'h10)) |=> busRdData == 16'h0051); // R4

  AST_CFI_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !armed && busWrData[7:0] == 8'h98 && busAddr == ADDR_W'(12'h055))
      |=> rdMode == RD_CFI); // R4

  AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !armed && busWrData[7:0] == 8'hF0) |=> rdMode == RD_ARRAY); // R5

  AST_PROG_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    progStb |-> (armed && busWr)); // R6

  AST_PROG_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    progStb |=> (!armed && rdMode == RD_ARRAY)); // R6

  AST_PLAIN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !armed) |-> !progStb); // R7

endmodule

bind norCmdIf norCmdChk #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWr    (busWr),
  .busRd    (busRd),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .rdMode   (ctrlStb.rdMode),
  .armed    (seqArmed),
  .progStb  (ctrlStb.progStb)
);

// File: tb/norCmdIf_test.sv
module norCmdIf_test;

  localparam int ADDR_W = 20;
  localparam int WORDS  = 64;
  localparam int unsigned AMASK = (1 << ADDR_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWr = 1'b0;
  logic              busRd = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [15:0]       busWrData = '0;
  logic [15:0]       busRdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model state: mode 0 array, 1 ID, 2 query; seq 0 idle,1,2 keys, 3 armed
  logic [15:0] mArr [WORDS];
  int mMode = 0;
  int mSeq  = 0;

  always #5 clk = ~clk;

  norCmdIf #(.ADDR_W(ADDR_W), .ARRAY_WORDS(WORDS)) uut (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busRd    (busRd),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .busRdData(busRdData)
  );

  function automatic logic [15:0] expRd(int unsigned a);
    if (mMode == 1) begin
      if (a == 0) return 16'h00C2;
      if (a == 1) return 16'h2249;
      return 16'h0000;
    end else if (mMode == 2) begin
      case (a)
        32'h10:  return 16'h0051;
        32'h11:  return 16'h0052;
        32'h12:  return 16'h0059;
        32'h27:  return 16'h0015;
        default: return 16'h0000;
      endcase
    end
    return mArr[a % WORDS];
  endfunction

  task automatic modelWr(int unsigned a, logic [15:0] d);
    logic [7:0] c;
    c = d[7:0];
    if (mSeq == 3) begin
      mArr[a % WORDS] = mArr[a % WORDS] & d;
      mSeq = 0;
      mMode = 0;
    end else if (c == 8'hF0) begin
      mSeq = 0;
      mMode = 0;
    end else if (c == 8'h98 && a == 32'h055) begin
      mSeq = 0;
      mMode = 2;
    end else begin
      case (mSeq)
        0: mSeq = (c == 8'hAA && a == 32'h555) ? 1 : 0;
        1: mSeq = (c == 8'h55 && a == 32'h2AA) ? 2 : 0;
        default: begin
          mSeq = 0;
          if (a == 32'h555 && c == 8'h90) mMode = 1;
          else if (a == 32'h555 && c == 8'hA0) mSeq = 3;
        end
      endcase
    end
  endtask

  task automatic chk(logic [15:0] act, logic [15:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(int unsigned a, logic [15:0] d);
    @(negedge clk);
    busWr = 1'b1;
    busAddr = a[ADDR_W-1:0];
    busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
    modelWr(a & AMASK, d);
  endtask

  task automatic busRead(int unsigned a, string tag);
    logic [15:0] e;
    @(negedge clk);
    busRd = 1'b1;
    busAddr = a[ADDR_W-1:0];
    e = expRd(a & AMASK);
    @(negedge clk);
    busRd = 1'b0;
    chk(busRdData, e, tag);
  endtask

  task automatic unlock(logic [7:0] cmd);
    busWrite(32'h555, 16'h00AA);
    busWrite(32'h2AA, 16'h0055);
    busWrite(32'h555, {8'h00, cmd});
  endtask

  task automatic randRead();
    int unsigned sel;
    int unsigned a;
    string tag;
    sel = $urandom % 9;
    case (sel)
      0: a = 0;
      1: a = 1;
      2: a = 32'h10;
      3: a = 32'h11;
      4: a = 32'h12;
      5: a = 32'h27;
      6: a = 32'h13;
      7: a = $urandom % WORDS;
      default: a = $urandom & AMASK;
    endcase
    tag = (mMode == 1) ? "R3 random id read" :
          (mMode == 2) ? "R4 random query read" : "R8 random array read";
    busRead(a, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    for (int i = 0; i < WORDS; i++) mArr[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk(busRdData, 16'h0000, "R1 reset read data");
    rstN = 1'b1;
    busRead(5, "R1 erased word");
    busRead(63, "R1 erased last word");

    // R7 plain writes ignored
    busWrite(5, 16'h0000);
    busRead(5, "R7 plain write ignored");

    // R3 ID mode
    unlock(8'h90);
    busRead(0, "R3 manufacturer code");
    chk(busRdData, 16'h00C2, "R3 manufacturer constant");
    busRead(1, "R3 device code");
    chk(busRdData, 16'h2249, "R3 device constant");
    repeat (4) @(negedge clk);
    chk(busRdData, 16'h2249, "R2 read data held");
    busRead(2, "R3 other id address");

    // R5 reset command
    busWrite(32'h3C1, 16'h12F0);
    busRead(5, "R5 back to array");

    // R4 query mode
    busWrite(32'h055, 16'h0098);
    busRead(32'h10, "R4 query Q");
    chk(busRdData, 16'h0051, "R4 query Q constant");
    busRead(32'h11, "R4 query R");
    busRead(32'h12, "R4 query Y");
    busRead(32'h27, "R4 size log2");
    chk(busRdData, 16'h0015, "R4 size constant");
    busRead(32'h13, "R4 unused query address");

    // R6 program from query mode, AND behaviour
    unlock(8'hA0);
    busWrite(5, 16'h1234);
    busRead(5, "R6 program word");
    chk(busRdData, 16'h1234, "R6 program constant");
    unlock(8'hA0);
    busWrite(5, 16'hFF00);
    busRead(5, "R6 program can only clear");
    chk(busRdData, 16'h1200, "R6 and constant");

    // R7 broken prefix
    busWrite(32'h555, 16'h00AA);
    busWrite(32'h2AB, 16'h0055);
    busWrite(32'h555, 16'h00A0);
    busWrite(5, 16'h0000);
    busRead(5, "R7 broken prefix no program");
    chk(busRdData, 16'h1200, "R7 word unchanged");

    // R8 aliasing
    busRead(5 + WORDS, "R8 alias read");
    unlock(8'hA0);
    busWrite(7 + 2 * WORDS, 16'h00FF);
    busRead(7, "R8 alias program");
    chk(busRdData, 16'h00FF, "R8 alias constant");

    // R5 reset drops partial prefix
    busWrite(32'h555, 16'h00AA);
    busWrite(32'h100, 16'h00F0);
    busWrite(32'h2AA, 16'h0055);
    busWrite(32'h555, 16'h0090);
    busRead(0, "R5 partial prefix dropped");
    chk(busRdData, 16'hFFFF, "R5 still array");

    // R6 armed write with reset byte still programs
    unlock(8'h90);
    unlock(8'hA0);
    busWrite(9, 16'h00F0);
    busRead(9, "R6 armed write programs");
    chk(busRdData, 16'h00F0, "R6 armed constant");

    // Random phase
    for (int i = 0; i < 800; i++) begin
      int unsigned k;
      int unsigned pick;
      k = $urandom % 10;
      case (k)
        4: busWrite($urandom & AMASK, 16'($urandom));
        5: begin
          pick = $urandom % 3;
          unlock(pick == 0 ? 8'h90 : (pick == 1 ? 8'hA0 : 8'($urandom)));
          if (mSeq == 3) busWrite($urandom % (4 * WORDS), 16'($urandom));
        end
        6: busWrite($urandom & AMASK, 16'h00F0);
        7: busWrite(32'h055, 16'h0098);
        8: begin
          busWrite(32'h555, 16'h00AA);
          if ($urandom % 2 == 1) busWrite(32'h2AA, 16'($urandom));
          else busWrite($urandom & AMASK, 16'h0055);
          busWrite($urandom % WORDS, 16'($urandom));
        end
        default: randRead();
      endcase
    end
    for (int i = 0; i < WORDS; i++) begin
      busWrite(32'h11, 16'h00F0);
      busRead(i, "R7 final array sweep");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule